// File: doc/BRIEF.md
# Device Disable Power Controller

This block decides when a network interface device enters or leaves its low-power disabled mode. A board-level agent requests the disabled mode by pulling an active-low pin. That pin is asynchronous to the device clock, so a synchronizer chain carries it into the clock domain first. The block honours the request only after the configuration memory has finished loading, and only when the loaded configuration permits the disabled mode.

While disabled, the block raises three controls together: a request for the host link to sit in the L3 state, a PHY power-down, and a global tri-state enable for the output buffers. A host-bus reset cannot pull the device out of the disabled mode while that reset is held. When the host-bus reset is released, the device leaves the disabled mode briefly and waits for the configuration reload to finish. After the reload it evaluates the request again. If the loaded configuration asks the device to drive the sideband management clock, a separate keep-alive output stays high in every mode, including the disabled one. A one-cycle event pulse marks each entry into the disabled mode and each exit from it.

Top module: `pwr_disable_ctrl`

## Requirements
- R1: While `rst_n` is low and right after it rises, `link_l3_req`, `phy_pwrdn`, `out_tristate`, `sbclk_keep` and `mode_evt` are all 0.
- R2: Until the first configuration load is accepted (`cfg_done` high while `bus_rst_n` is high), an asserted `disable_req_n` (low) has no effect, and the three power controls stay 0.
- R3: The disabled mode is entered only if the `cfg_dis_allow` value captured at the last accepted load is 1. If that value is 0, the request is ignored.
- R4: When all gating conditions hold, the three power controls rise at the third rising clock edge after `disable_req_n` falls: two synchronizer edges, then one state edge.
- R5: `link_l3_req`, `phy_pwrdn` and `out_tristate` are all 1 in the disabled mode and all 0 in every other mode.
- R6: While the device is disabled, asserting `bus_rst_n` (driving it low) and holding it low leaves the device disabled, as long as the request stays asserted.
- R7: If `bus_rst_n` rises while the device is disabled, the power controls drop to 0 at the next rising edge. They stay 0 until a load is accepted. At the edge that accepts the load, the device enters the enabled mode. If the request is still asserted, the device becomes disabled again one edge later.
- R8: Driving `disable_req_n` high while disabled clears the three power controls at the third rising edge after the change.
- R9: `sbclk_keep` equals the `cfg_sbclk_out_en` value captured at the last accepted load, in every mode including the disabled one. It changes only at an edge that accepts a load.
- R10: `mode_evt` is 1 for exactly the one cycle after each edge at which the device enters or leaves the disabled mode, and 0 otherwise.
- R11: A low `bus_rst_n` while the device is enabled sends it to a reload wait. In that wait, `cfg_done` is ignored while `bus_rst_n` is low and the request is ignored until a load is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assertion |
| disable_req_n | input | 1 | Disable request, active low, asynchronous to `clk` |
| bus_rst_n | input | 1 | Host-bus reset, active low, already synchronous to `clk` |
| cfg_done | input | 1 | Strobe marking completion of a configuration-memory load |
| cfg_dis_allow | input | 1 | Loaded bit permitting the disabled mode, valid with `cfg_done` |
| cfg_sbclk_out_en | input | 1 | Loaded bit selecting output of the sideband management clock, valid with `cfg_done` |
| link_l3_req | output | 1 | Request for the host link to go to L3 |
| phy_pwrdn | output | 1 | PHY power-down |
| out_tristate | output | 1 | Global output-buffer tri-state enable |
| sbclk_keep | output | 1 | Keep the sideband clock output running |
| mode_evt | output | 1 | One-cycle pulse on each entry into or exit from the disabled mode |

## Verification
On every cycle, the assertions check four things: that entry into the disabled mode needs a prior accepted load, an allowed configuration and a synchronized request; that a held host-bus reset keeps the disabled mode; that releasing that reset ends the disabled mode; and that the event pulse and the clock keep-alive move only when they should. Only the bench's scenarios can show the exact edge counts of entry and exit, and that a request made before any load stays inert. The same holds for the reload wait that follows a bus reset from the enabled mode, and for the sweep over all four combinations of the two configuration bits.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

    typedef enum logic [2:0] {
        ST_BOOT_WAIT   = 3'b000,
        ST_ON          = 3'b001,
        ST_OFF         = 3'b010,
        ST_RELOAD_WAIT = 3'b100
    } pdc_state_e;

    typedef struct packed {
        pdc_state_e state;
        logic       allow;
        logic       sbclk;
        logic       rst_prev;
        logic       pulse;
    } pdc_regs_t;

    localparam pdc_regs_t PDC_RESET = '{
        state:    ST_BOOT_WAIT,
        allow:    1'b0,
        sbclk:    1'b0,
        rst_prev: 1'b1,
        pulse:    1'b0
    };

endpackage

// File: rtl/pdc_sync.sv
module pdc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    generate
        if (STAGES < 2) begin : g_single
            logic flop_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) flop_q <= RST_VAL;
                else        flop_q <= d;
            end
            assign q = flop_q;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL}};
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
            assign q = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/pdc_fsm.sv
module pdc_fsm
    import pdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_act,
    input  logic       bus_rst_n,
    input  logic       cfg_done,
    input  logic       cfg_allow_in,
    input  logic       cfg_sbclk_in,
    output pdc_state_e state_o,
    output logic       allow_o,
    output logic       sbclk_o,
    output logic       pulse_o
);

    pdc_regs_t r_q;
    pdc_regs_t r_d;
    logic      load_ok;
    logic      bus_release;

    always_comb begin
        r_d          = r_q;
        r_d.rst_prev = bus_rst_n;
        load_ok      = cfg_done && bus_rst_n;
        bus_release  = bus_rst_n && !r_q.rst_prev;

        case (r_q.state)
            ST_BOOT_WAIT, ST_RELOAD_WAIT: begin
                if (load_ok) begin
                    r_d.state = ST_ON;
                    r_d.allow = cfg_allow_in;
                    r_d.sbclk = cfg_sbclk_in;
                end
            end
            ST_ON: begin
                if (!bus_rst_n)
                    r_d.state = ST_RELOAD_WAIT;
                else if (req_act && r_q.allow)
                    r_d.state = ST_OFF;
            end
            ST_OFF: begin
                if (bus_release)
                    r_d.state = ST_RELOAD_WAIT;
                else if (!req_act)
                    r_d.state = ST_ON;
            end
            default: r_d.state = ST_BOOT_WAIT;
        endcase

        r_d.pulse = (r_d.state == ST_OFF) != (r_q.state == ST_OFF);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= PDC_RESET;
        else        r_q <= r_d;
    end

    assign state_o = r_q.state;
    assign allow_o = r_q.allow;
    assign sbclk_o = r_q.sbclk;
    assign pulse_o = r_q.pulse;

endmodule

// File: rtl/pdc_outmap.sv
module pdc_outmap
    import pdc_pkg::*;
(
    input  pdc_state_e state_i,
    input  logic       sbclk_i,
    output logic       link_l3_o,
    output logic       phy_pwrdn_o,
    output logic       tristate_o,
    output logic       sbclk_keep_o
);

    logic off_mode;

    always_comb begin
        off_mode     = (state_i == ST_OFF);
        link_l3_o    = off_mode;
        phy_pwrdn_o  = off_mode;
        tristate_o   = off_mode;
        sbclk_keep_o = sbclk_i;
    end

endmodule

// File: rtl/pwr_disable_ctrl.sv
module pwr_disable_ctrl
    import pdc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic disable_req_n,
    input  logic bus_rst_n,
    input  logic cfg_done,
    input  logic cfg_dis_allow,
    input  logic cfg_sbclk_out_en,
    output logic link_l3_req,
    output logic phy_pwrdn,
    output logic out_tristate,
    output logic sbclk_keep,
    output logic mode_evt
);

    logic       req_n_sync;
    logic       req_act;
    logic       allow_q;
    logic       sbclk_q;
    pdc_state_e state_q;

    pdc_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (disable_req_n),
        .q     (req_n_sync)
    );

    assign req_act = ~req_n_sync;

    pdc_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_act      (req_act),
        .bus_rst_n    (bus_rst_n),
        .cfg_done     (cfg_done),
        .cfg_allow_in (cfg_dis_allow),
        .cfg_sbclk_in (cfg_sbclk_out_en),
        .state_o      (state_q),
        .allow_o      (allow_q),
        .sbclk_o      (sbclk_q),
        .pulse_o      (mode_evt)
    );

    pdc_outmap u_outmap (
        .state_i      (state_q),
        .sbclk_i      (sbclk_q),
        .link_l3_o    (link_l3_req),
        .phy_pwrdn_o  (phy_pwrdn),
        .tristate_o   (out_tristate),
        .sbclk_keep_o (sbclk_keep)
    );

endmodule

// File: rtl/pdc_chk.sv
module pdc_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_rst_n,
    input logic cfg_done,
    input logic req_act,
    input logic allow_q,
    input logic link_l3_req,
    input logic sbclk_keep,
    input logic mode_evt
);

    logic cfg_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cfg_seen_q <= 1'b0;
        else if (cfg_done && bus_rst_n) cfg_seen_q <= 1'b1;
    end

    AST_NO_ENTRY_BEFORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        link_l3_req |-> cfg_seen_q); // R2

    AST_ENTRY_NEEDS_ALLOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_l3_req) |-> allow_q); // R3

    AST_ENTRY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_l3_req) |-> $past(req_act)); // R4

    AST_BUSRST_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (link_l3_req && !bus_rst_n && req_act) |=> link_l3_req); // R6

    AST_RELEASE_LEAVES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (link_l3_req && bus_rst_n && !$past(bus_rst_n)) |=> !link_l3_req); // R7

    AST_SBCLK_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sbclk_keep) |-> $past(cfg_done && bus_rst_n)); // R9

    AST_EVT_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_evt == (link_l3_req != $past(link_l3_req))); // R10

endmodule

bind pwr_disable_ctrl pdc_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_rst_n   (bus_rst_n),
    .cfg_done    (cfg_done),
    .req_act     (req_act),
    .allow_q     (allow_q),
    .link_l3_req (link_l3_req),
    .sbclk_keep  (sbclk_keep),
    .mode_evt    (mode_evt)
);

// File: tb/sim_pwr_disable_ctrl.sv
module sim_pwr_disable_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic disable_req_n = 1'b1;
    logic bus_rst_n = 1'b1;
    logic cfg_done = 1'b0;
    logic cfg_dis_allow = 1'b0;
    logic cfg_sbclk_out_en = 1'b0;
    logic link_l3_req, phy_pwrdn, out_tristate, sbclk_keep, mode_evt;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    pwr_disable_ctrl u0 (
        .clk              (clk),
        .rst_n            (rst_n),
        .disable_req_n    (disable_req_n),
        .bus_rst_n        (bus_rst_n),
        .cfg_done         (cfg_done),
        .cfg_dis_allow    (cfg_dis_allow),
        .cfg_sbclk_out_en (cfg_sbclk_out_en),
        .link_l3_req      (link_l3_req),
        .phy_pwrdn        (phy_pwrdn),
        .out_tristate     (out_tristate),
        .sbclk_keep       (sbclk_keep),
        .mode_evt         (mode_evt)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_pwr(input string tag, input int exp);
        chk({tag, " link_l3_req"}, int'(link_l3_req), exp);
        chk({tag, " phy_pwrdn"}, int'(phy_pwrdn), exp);
        chk({tag, " out_tristate"}, int'(out_tristate), exp);
    endtask

    task automatic load(input logic a, input logic s);
        cfg_dis_allow = a;
        cfg_sbclk_out_en = s;
        cfg_done = 1'b1;
        tick(1);
        cfg_done = 1'b0;
        cfg_dis_allow = 1'b0;
        cfg_sbclk_out_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int combo = 0; combo < 4; combo++) begin
            logic a, s;
            a = combo[0];
            s = combo[1];
            rst_n = 1'b0;
            disable_req_n = 1'b1;
            bus_rst_n = 1'b1;
            cfg_done = 1'b0;
            tick(3);
            chk_pwr("R1 in reset", 0);
            rst_n = 1'b1;
            tick(1);
            chk_pwr("R1 after reset", 0);
            chk("R1 sbclk_keep", int'(sbclk_keep), 0);
            chk("R1 mode_evt", int'(mode_evt), 0);

            disable_req_n = 1'b0;
            tick(5);
            chk_pwr("R2 request before load", 0);
            chk("R2 no event", int'(mode_evt), 0);

            load(a, s);
            chk("R9 sbclk after load", int'(sbclk_keep), int'(s));
            chk_pwr("R7 load edge enters enabled", 0);
            chk("R10 no event on load", int'(mode_evt), 0);
            tick(1);
            chk_pwr("R3 entry follows allow", int'(a));
            chk("R10 entry event", int'(mode_evt), int'(a));
            tick(1);
            chk("R10 event one cycle", int'(mode_evt), 0);

            if (a) begin
                chk_pwr("R5 disabled", 1);
                bus_rst_n = 1'b0;
                tick(4);
                chk_pwr("R6 bus reset held", 1);
                chk("R9 sbclk while disabled", int'(sbclk_keep), int'(s));

                bus_rst_n = 1'b1;
                tick(1);
                chk_pwr("R7 release leaves disabled", 0);
                chk("R10 exit event", int'(mode_evt), 1);
                tick(3);
                chk_pwr("R7 waits for reload", 0);
                load(a, s);
                chk_pwr("R7 reload edge enabled", 0);
                tick(1);
                chk_pwr("R7 re-entry after reload", 1);

                disable_req_n = 1'b1;
                tick(2);
                chk_pwr("R8 before third edge", 1);
                tick(1);
                chk_pwr("R8 exit at third edge", 0);

                disable_req_n = 1'b0;
                tick(2);
                chk_pwr("R4 before third edge", 0);
                tick(1);
                chk_pwr("R4 entry at third edge", 1);

                disable_req_n = 1'b1;
                tick(3);
                chk_pwr("R8 exit again", 0);
                bus_rst_n = 1'b0;
                tick(1);
                disable_req_n = 1'b0;
                tick(4);
                chk_pwr("R11 bus reset in enabled", 0);
                cfg_done = 1'b1;
                cfg_dis_allow = 1'b1;
                tick(1);
                cfg_done = 1'b0;
                cfg_dis_allow = 1'b0;
                tick(3);
                chk_pwr("R11 load ignored under bus reset", 0);
                bus_rst_n = 1'b1;
                tick(4);
                chk_pwr("R11 request ignored before reload", 0);
                load(a, s);
                tick(1);
                chk_pwr("R11 entry after reload", 1);
            end else begin
                disable_req_n = 1'b1;
                tick(4);
                disable_req_n = 1'b0;
                tick(6);
                chk_pwr("R3 not allowed", 0);
                chk("R10 no event when not allowed", int'(mode_evt), 0);
                chk("R9 sbclk steady", int'(sbclk_keep), int'(s));
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule